// File: doc/BRIEF.md
# Power-Fail Reset Supervisor with Watchdog

This block watches a supply-fault flag and a software watchdog, and drives an active-low reset for a host processor. The supply-fault flag comes from an analog comparator outside the block. The block passes the comparator its 2-bit trip-threshold selection. When the flag rises, or the watchdog runs out, reset goes low. Reset then stays low for a fixed recovery interval before it is released. A retimed millisecond tick sets every delay. The prescaler behind the tick is a parameter, so a test can shorten all delays by the same factor.

While reset is low, the block raises a lockout for the serial bus. It also closes the memory array, but only once any memory operation that was already running has finished. Configuration arrives on a plain write-enable, address and data port. A single-cycle strobe restarts the watchdog.

Top module: `pfr_supervisor`

## Requirements
- R1: During `rst_n` low, `rst_out_n`=0, `bus_lock_o`=1, `array_lock_o`=1 and `trip_sel_o`=00. After `rst_n` rises, `rst_out_n` rises exactly 50×CLK_PER_MS rising edges later.
- R2: `supply_low_i` passes through a 2-flop synchronizer. A rise of `supply_low_i` before edge 1 drives `rst_out_n` low after edge 3. It then stays low for as long as the flag is high.
- R3: When `supply_low_i` falls, `rst_out_n` rises exactly 3+50×CLK_PER_MS edges later. If the flag returns during that recovery interval, reset stays low and the 50 ms count starts again from zero once the flag falls again.
- R4: `bus_lock_o` is high exactly while `rst_out_n` is low.
- R5: `array_lock_o` goes high together with reset if `mem_busy_i` is 0. If `mem_busy_i` is 1, the array stays open until the first cycle with `mem_busy_i`=0, and is locked one edge later. After that it stays locked until reset releases, whatever `mem_busy_i` does.
- R6: A write to address 0x18 loads `cfg_wdata_i[1:0]` into `trip_sel_o` one edge later. The codes 00, 01, 10 and 11 select 2.6 V, 2.75 V, 2.9 V and 3.0 V. Writes to other addresses leave it unchanged.
- R7: A write to address 0x0C sets the watchdog. Bit 7 is the enable and bits 4:0 are the step code N. The timeout is N×60 ms. Code 0 acts as 1 and codes above 30 act as 30. While the watchdog is disabled, it never asserts reset.
- R8: A `wd_kick_i` pulse or a watchdog-register write restarts the count. With no further restart, reset goes low exactly timeout×CLK_PER_MS edges after the edge that sampled the restart.
- R9: A watchdog expiry holds reset low for exactly 50×CLK_PER_MS edges. The watchdog then restarts from zero and expires again one full timeout after the release.
- R10: While reset is active, kicks are ignored and the watchdog is held cleared. Kicks do not change the recovery length. After a supply-fault reset, the full timeout runs from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low_i | input | 1 | Comparator output, high when supply is below trip (asynchronous) |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | ADDR_W | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| wd_kick_i | input | 1 | Watchdog restart strobe |
| mem_busy_i | input | 1 | A memory operation is in progress |
| trip_sel_o | output | 2 | Trip threshold code to the comparator |
| rst_out_n | output | 1 | Active-low processor reset |
| bus_lock_o | output | 1 | Refuse new serial transactions |
| array_lock_o | output | 1 | Memory array closed |

## Verification
Reset is driven by three sources, which the stimulus separates: a power-up reset, a steady supply fault, and a fault that returns in the middle of recovery. The returning fault shows whether the recovery count truly restarts or only pauses. A table of watchdog step codes (0, 1, 2, 5, 30, 31) measures the expiry period, the recovery length and the re-armed period. These values separate correct clamping at both ends of the code range from wrap-around. Kicks given during a recovery interval, and a supply fault partway through a watchdog period, show that the watchdog is cleared while reset is active rather than merely paused. The array-lock tests run a memory operation that is busy, then idle, then busy again, to check that the lock is delayed and then held.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FAULT   = 2'd1,
    ST_RECOVER = 2'd2
  } sup_state_e;
endpackage

// File: rtl/pfr_sync.sv
module pfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= {q_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = q_q[STAGES-1];
endmodule

// File: rtl/pfr_tick_gen.sv
module pfr_tick_gen #(
  parameter int CLK_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(CLK_PER_MS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  generate
    if (CLK_PER_MS > 1) begin : g_spacing_chk
      // Ticks are isolated pulses: the base of every millisecond count (R3)
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("tick repeated on consecutive cycles");
    end
  endgenerate
endmodule

// File: rtl/pfr_watchdog.sv
module pfr_watchdog #(
  parameter int STEP_MS   = 60,
  parameter int MAX_STEPS = 30,
  parameter int CODE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              hold_i,
  input  logic              restart_i,
  input  logic              tick_i,
  output logic              expire_o
);
  localparam int LIMIT_MAX = STEP_MS * MAX_STEPS;
  localparam int CW        = $clog2(LIMIT_MAX + 1);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_STEPS);

  logic [CODE_W-1:0] steps;
  logic [CW-1:0]     limit;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    if (code_i == '0)           steps = CODE_W'(1);
    else if (code_i > MAX_CODE) steps = MAX_CODE;
    else                        steps = code_i;
  end

  assign limit = CW'(steps) * CW'(STEP_MS);

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (hold_i || restart_i || !en_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == limit - CW'(1)) begin
        expire_o = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_no_expire_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !expire_o) else $error("watchdog expired while held");

  assert_expire_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (en_i && tick_i)) else $error("watchdog expired while disabled or off-tick");
endmodule

// File: rtl/pfr_reset_fsm.sv
module pfr_reset_fsm
  import pfr_pkg::*;
#(
  parameter int RECOV_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic wd_expire_i,
  input  logic tick_i,
  output logic rst_n_o,
  output logic running_o,
  output logic in_reset_next_o,
  output logic enter_rec_o
);
  localparam int RW = $clog2(RECOV_MS + 1);

  sup_state_e    state_q, state_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          rst_n_q;

  always_comb begin
    state_d     = state_q;
    rcnt_d      = rcnt_q;
    enter_rec_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (fault_i) begin
          state_d = ST_FAULT;
        end else if (wd_expire_i) begin
          state_d     = ST_RECOVER;
          rcnt_d      = '0;
          enter_rec_o = 1'b1;
        end
      end
      ST_FAULT: begin
        if (!fault_i) begin
          state_d     = ST_RECOVER;
          rcnt_d      = '0;
          enter_rec_o = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (fault_i) begin
          state_d = ST_FAULT;
          rcnt_d  = '0;
        end else if (tick_i) begin
          if (rcnt_q == RW'(RECOV_MS - 1)) begin
            state_d = ST_RUN;
            rcnt_d  = '0;
          end else begin
            rcnt_d = rcnt_q + RW'(1);
          end
        end
      end
      default: state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RECOVER;
      rcnt_q  <= '0;
      rst_n_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= rcnt_d;
      rst_n_q <= (state_d == ST_RUN);
    end
  end

  assign rst_n_o         = rst_n_q;
  assign running_o       = (state_q == ST_RUN);
  assign in_reset_next_o = (state_d != ST_RUN);

  assert_fault_forces_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !rst_n_q) else $error("reset not low during supply fault");

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_q) |-> ($past(tick_i) && !$past(fault_i)))
    else $error("reset released off-tick or during fault");

  assert_wd_expiry_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expire_i && !fault_i && running_o) |=> !rst_n_q)
    else $error("watchdog expiry did not assert reset");
endmodule

// File: rtl/pfr_supervisor.sv
module pfr_supervisor #(
  parameter int              CLK_PER_MS   = 100000,
  parameter int              RECOV_MS     = 50,
  parameter int              WD_STEP_MS   = 60,
  parameter int              WD_MAX_STEPS = 30,
  parameter int              SYNC_STAGES  = 2,
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] TRIP_ADDR  = ADDR_W'(8'h18),
  parameter logic [ADDR_W-1:0] WD_ADDR    = ADDR_W'(8'h0C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_low_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              wd_kick_i,
  input  logic              mem_busy_i,
  output logic [1:0]        trip_sel_o,
  output logic              rst_out_n,
  output logic              bus_lock_o,
  output logic              array_lock_o
);
  localparam int CODE_W = 5;

  logic [1:0]        trip_q, trip_d;
  logic              wd_en_q, wd_en_d;
  logic [CODE_W-1:0] wd_code_q, wd_code_d;
  logic              lock_q, lock_d;
  logic              trip_wr, wd_wr;
  logic              fault_s, tick, tick_clr, wd_expire, wd_restart;
  logic              fsm_rst_n, running, in_reset_next, enter_rec;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[6:5];

  assign trip_wr = cfg_we_i && (cfg_addr_i == TRIP_ADDR);
  assign wd_wr   = cfg_we_i && (cfg_addr_i == WD_ADDR);

  always_comb begin
    trip_d    = trip_q;
    wd_en_d   = wd_en_q;
    wd_code_d = wd_code_q;
    if (trip_wr) trip_d = cfg_wdata_i[1:0];
    if (wd_wr) begin
      wd_en_d   = cfg_wdata_i[7];
      wd_code_d = cfg_wdata_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q    <= '0;
      wd_en_q   <= 1'b0;
      wd_code_q <= '0;
    end else begin
      trip_q    <= trip_d;
      wd_en_q   <= wd_en_d;
      wd_code_q <= wd_code_d;
    end
  end

  pfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (supply_low_i),
    .q_o   (fault_s)
  );

  // Restarts only count while the host is out of reset
  assign wd_restart = running && (wd_kick_i || wd_wr);
  assign tick_clr   = enter_rec || wd_restart;

  pfr_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tick_clr),
    .tick_o (tick)
  );

  pfr_watchdog #(
    .STEP_MS   (WD_STEP_MS),
    .MAX_STEPS (WD_MAX_STEPS),
    .CODE_W    (CODE_W)
  ) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wd_en_q),
    .code_i    (wd_code_q),
    .hold_i    (!running),
    .restart_i (wd_restart),
    .tick_i    (tick),
    .expire_o  (wd_expire)
  );

  pfr_reset_fsm #(.RECOV_MS(RECOV_MS)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .fault_i         (fault_s),
    .wd_expire_i     (wd_expire),
    .tick_i          (tick),
    .rst_n_o         (fsm_rst_n),
    .running_o       (running),
    .in_reset_next_o (in_reset_next),
    .enter_rec_o     (enter_rec)
  );

  // Array closes at the first idle cycle inside reset and stays closed
  always_comb begin
    lock_d = in_reset_next && (lock_q || !mem_busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_d;
  end

  assign trip_sel_o   = trip_q;
  assign rst_out_n    = fsm_rst_n;
  assign bus_lock_o   = !fsm_rst_n;
  assign array_lock_o = lock_q;

  assert_lock_waits_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !$past(mem_busy_i)) else $error("array locked mid-operation");

  assert_lock_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && in_reset_next) |=> lock_q) else $error("array lock dropped inside reset");

  assert_trip_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_wr |=> (trip_sel_o == $past(cfg_wdata_i[1:0]))) else $error("trip field not loaded");
endmodule

// File: tb/pfr_supervisor_bench.sv
module pfr_supervisor_bench;
  localparam int P     = 4;
  localparam int RECOV = 50 * P;
  localparam int STEP  = 60 * P;
  localparam logic [7:0] TRIP_A = 8'h18;
  localparam logic [7:0] WD_A   = 8'h0C;

  typedef struct packed {
    logic [4:0] code;
    logic [7:0] steps;
  } wd_vec_t;

  localparam wd_vec_t VECS [6] = '{
    '{code: 5'd0,  steps: 8'd1},
    '{code: 5'd1,  steps: 8'd1},
    '{code: 5'd2,  steps: 8'd2},
    '{code: 5'd5,  steps: 8'd5},
    '{code: 5'd30, steps: 8'd30},
    '{code: 5'd31, steps: 8'd30}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_low_i, cfg_we_i, wd_kick_i, mem_busy_i;
  logic [7:0] cfg_addr_i, cfg_wdata_i;
  logic [1:0] trip_sel_o;
  logic       rst_out_n, bus_lock_o, array_lock_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  pfr_supervisor #(.CLK_PER_MS(P)) u_pfr_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .wd_kick_i    (wd_kick_i),
    .mem_busy_i   (mem_busy_i),
    .trip_sel_o   (trip_sel_o),
    .rst_out_n    (rst_out_n),
    .bus_lock_o   (bus_lock_o),
    .array_lock_o (array_lock_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic kick();
    wd_kick_i = 1'b1;
    step();
    wd_kick_i = 1'b0;
  endtask

  // Steps until rst_out_n reaches lvl
  task automatic wait_lvl(input logic lvl, output int n);
    n = 0;
    while (rst_out_n !== lvl && n < 20000) begin
      step();
      n++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    int n;
    logic stayed_low;
    rst_n = 1'b0; supply_low_i = 1'b0; cfg_we_i = 1'b0; wd_kick_i = 1'b0;
    mem_busy_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    steps(3);
    check("R1 rst_out_n in reset", rst_out_n, 0);
    check("R1 bus_lock in reset", bus_lock_o, 1);
    check("R1 array_lock in reset", array_lock_o, 1);
    check("R1 trip reset value", trip_sel_o, 0);
    rst_n = 1'b1;
    wait_lvl(1'b1, n);
    check("R1 power-up hold length", n, RECOV);
    check("R4 bus_lock after release", bus_lock_o, 0);
    check("R5 array open after release", array_lock_o, 0);

    // R6 trip register
    for (int c = 0; c < 4; c++) begin
      wr(TRIP_A, {6'h2A, c[1:0]});
      check("R6 trip code", trip_sel_o, c);
    end
    wr(8'h19, 8'h01);
    check("R6 other address ignored", trip_sel_o, 3);

    // R7 disabled watchdog never fires
    steps(2000);
    check("R7 disabled watchdog", rst_out_n, 1);

    // R2 / R3 / R4 supply fault
    supply_low_i = 1'b1;
    steps(2);
    check("R2 not yet low after 2 edges", rst_out_n, 1);
    step();
    check("R2 low after 3 edges", rst_out_n, 0);
    check("R4 bus_lock with reset", bus_lock_o, 1);
    steps(300);
    check("R2 held during fault", rst_out_n, 0);
    supply_low_i = 1'b0;
    wait_lvl(1'b1, n);
    check("R3 recovery length", n, 3 + RECOV);
    check("R4 bus_lock released", bus_lock_o, 0);

    // R3 fault returns during recovery
    supply_low_i = 1'b1;
    steps(3);
    supply_low_i = 1'b0;
    stayed_low = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step();
      if (rst_out_n) stayed_low = 1'b0;
    end
    supply_low_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      if (rst_out_n) stayed_low = 1'b0;
    end
    supply_low_i = 1'b0;
    wait_lvl(1'b1, n);
    check("R3 stayed low through re-fault", stayed_low, 1);
    check("R3 count restarted", n, 3 + RECOV);

    // R5 memory operation in progress
    mem_busy_i = 1'b1;
    supply_low_i = 1'b1;
    steps(3);
    check("R5 reset active", rst_out_n, 0);
    check("R5 array open while busy", array_lock_o, 0);
    steps(5);
    check("R5 array still open", array_lock_o, 0);
    mem_busy_i = 1'b0;
    step();
    check("R5 array locked after op", array_lock_o, 1);
    mem_busy_i = 1'b1;
    step();
    check("R5 lock sticky", array_lock_o, 1);
    mem_busy_i = 1'b0;
    supply_low_i = 1'b0;
    wait_lvl(1'b1, n);
    check("R5 lock cleared at release", array_lock_o, 0);
    supply_low_i = 1'b1;
    steps(3);
    check("R5 idle locks at once", array_lock_o, 1);
    supply_low_i = 1'b0;
    wait_lvl(1'b1, n);

    // R7 / R8 / R9 watchdog code table
    foreach (VECS[v]) begin
      wr(WD_A, {3'b100, VECS[v].code});
      wait_lvl(1'b0, n);
      check("R7 timeout for code", n, int'(VECS[v].steps) * STEP);
      wait_lvl(1'b1, n);
      check("R9 watchdog recovery", n, RECOV);
      wait_lvl(1'b0, n);
      check("R9 re-armed period", n, int'(VECS[v].steps) * STEP);
      wr(WD_A, 8'h00);
      wait_lvl(1'b1, n);
    end

    // R8 kicks keep the host alive
    wr(WD_A, 8'h81);
    for (int k = 0; k < 5; k++) begin
      steps(200);
      kick();
    end
    check("R8 kicked watchdog quiet", rst_out_n, 1);
    wait_lvl(1'b0, n);
    check("R8 expiry after last kick", n, STEP);

    // R10 kicks during recovery ignored
    n = 0;
    while (!rst_out_n && n < 20000) begin
      if (n % 20 == 5) wd_kick_i = 1'b1;
      step();
      wd_kick_i = 1'b0;
      n++;
    end
    check("R10 recovery unchanged by kicks", n, RECOV);

    // R10 watchdog cleared by supply-fault reset
    steps(150);
    supply_low_i = 1'b1;
    steps(13);
    supply_low_i = 1'b0;
    wait_lvl(1'b1, n);
    wait_lvl(1'b0, n);
    check("R10 full timeout after fault", n, STEP);
    wr(WD_A, 8'h00);
    wait_lvl(1'b1, n);
    steps(600);
    check("R7 watchdog disabled again", rst_out_n, 1);

    summary();
    $finish;
  end
endmodule